// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filtering

This block receives asynchronous serial characters on a single line and holds the latest one in a one-character data register for a processor. The line is oversampled on an external sample-enable pulse: one bit spans 16 enabled cycles in normal mode or 8 in double-speed mode. Characters carry one low start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. There is no parity.

The processor reaches the block through two strobes. A control write loads the mode bits, and a data read takes the held character. The block reports a receive-complete flag, a framing-error flag, an overrun flag and the ninth received bit. It also raises an interrupt line when receive-complete is set and its enable bit is on.

The overrun flag is buffered. If a new character completes while the old one is still unread, the new one is lost and the old one is kept. The flag appears only when the processor reads that old character. In address-filter mode, frames whose address bit is zero are thrown away without touching any flag, so a node waits for an address frame. Software leaves this mode itself once the node has been addressed.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, statusOut (bit 3 receive-complete, bit 2 framing error, bit 1 overrun, bit 0 ninth bit) reads 4'b0001, irq is 0 and ctrlRdata is 0.
- R2: ctrlWdata/ctrlRdata fields are bit 0 enable, bit 1 nine-bit mode, bit 2 double speed, bit 3 address filter, bit 4 interrupt enable. With sampleEn high every cycle, a bit lasts 16 cycles, or 8 cycles with double speed set. Each received 8-bit character appears on rdData with receive-complete set and the framing error clear.
- R3: In nine-bit mode, the ninth data bit is reported in statusOut bit 0, and the lower eight bits are on rdData.
- R4: A character that completes while receive-complete is still set is discarded and the old data is kept. The overrun flag stays 0 until the next data read, and reads 1 from then on.
- R5: A data read clears receive-complete. The next character loaded without overrun clears the overrun flag.
- R6: With the address filter on, a frame whose address bit (ninth bit in nine-bit mode, stop bit in 8-bit mode) is 0 changes neither data nor flags. A frame whose address bit is 1 is loaded normally.
- R7: With enable clear, no frame is received and no flag is set. Flags already set stay as they are.
- R8: The framing-error flag is 1 exactly when the sampled stop bit of the last loaded character was 0.
- R9: irq is 1 exactly when the interrupt-enable bit and receive-complete are both 1.
- R10: A low pulse on the line shorter than half a bit is rejected as a false start, and nothing is received.
- R11: Each bit is decided by a majority of three samples around mid-bit, so a one-sample glitch at mid-bit does not change the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Oversampling enable pulse from the baud generator |
| rxd | input | 1 | Serial line, idles high |
| ctrlWr | input | 1 | Strobe to write the control register |
| ctrlWdata | input | 5 | Control value, fields as in R2 |
| dataRd | input | 1 | Strobe to read the data register |
| rdData | output | 8 | Held character |
| ctrlRdata | output | 5 | Control register readback |
| statusOut | output | 4 | Flags, fields as in R1 |
| irq | output | 1 | Receive-complete interrupt |

## Verification
A frame's flags and data are decided at the middle of its stop bit. That decision is delayed by the two-stage line synchronizer and then registered once, so the result lands a few cycles after the stop-bit centre. The bench therefore drives the whole stop bit plus several idle cycles before it samples anything. A read or control write takes effect on the clock edge that ends its one-cycle strobe. The bench drives strobes on the falling edge and samples on the next falling edge after the strobe is dropped. The same checks run at both bit periods.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
  // Index width of the character shift register; covers up to 9 data bits.
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // Strobes from bit control to the datapath.
  typedef struct packed {
    logic             sampleBit;  // a data bit was decided this cycle
    logic [IDX_W-1:0] bitIdx;     // position of that bit
    logic             bitVal;     // voted value (data bit or stop bit)
    logic             frameDone;  // stop bit decided; bitVal holds it
  } rxStrobe_t;
endpackage

// File: rtl/uart_mp_rx_ctrl.sv
module uart_mp_rx_ctrl
  import uart_mp_rx_pkg::*;
#(
  parameter int OVS_SLOW = 16,
  parameter int OVS_FAST = 8,
  parameter int DATA_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxd,
  input  logic       rxEn,
  input  logic       nineBit,
  input  logic       dblSpeed,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(OVS_SLOW);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(OVS_SLOW - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(OVS_FAST - 1);
  localparam logic [CNT_W-1:0] MID_SLOW  = CNT_W'(OVS_SLOW / 2);
  localparam logic [CNT_W-1:0] MID_FAST  = CNT_W'(OVS_FAST / 2);

  rxState_t         state;
  logic [1:0]       syncQ;
  logic             rxdS;
  logic [CNT_W-1:0] cnt, lastCnt, midCnt;
  logic [IDX_W-1:0] bitIdx, lastIdx;
  logic [1:0]       win;
  logic             vote, decide;

  assign rxdS    = syncQ[1];
  assign lastCnt = dblSpeed ? LAST_FAST : LAST_SLOW;
  assign midCnt  = dblSpeed ? MID_FAST : MID_SLOW;
  assign lastIdx = nineBit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign vote    = (win[1] & win[0]) | (win[1] & rxdS) | (win[0] & rxdS);
  assign decide  = rxEn && sampleEn && (state != ST_IDLE) && (cnt == midCnt + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      win    <= 2'b11;
    end else if (!rxEn) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (sampleEn) begin
      if (state == ST_IDLE) begin
        if (!rxdS) begin
          state  <= ST_START;
          cnt    <= '0;
          bitIdx <= '0;
        end
      end else begin
        if (cnt == midCnt - 1'b1 || cnt == midCnt) win <= {win[0], rxdS};
        if (cnt == lastCnt) cnt <= '0;
        else                cnt <= cnt + 1'b1;
        if (decide && state == ST_START && vote) begin
          state <= ST_IDLE;
        end else if (decide && state == ST_STOP) begin
          state <= ST_IDLE;
        end else if (cnt == lastCnt) begin
          if (state == ST_START) begin
            state <= ST_DATA;
          end else if (state == ST_DATA) begin
            if (bitIdx == lastIdx) state <= ST_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobe.sampleBit = decide && (state == ST_DATA);
    strobe.bitIdx    = bitIdx;
    strobe.bitVal    = vote;
    strobe.frameDone = decide && (state == ST_STOP);
  end

  // R7: a disabled receiver is held idle
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> state == ST_IDLE);
  // R2: a finished frame returns to hunting for a start bit
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |=> state == ST_IDLE);
endmodule

// File: rtl/uart_mp_rx_dp.sv
module uart_mp_rx_dp
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              ctrlWr,
  input  logic [4:0]        ctrlWdata,
  input  logic              dataRd,
  output logic              rxEn,
  output logic              nineBit,
  output logic              dblSpeed,
  output logic              mpMode,
  output logic              rxcIe,
  output logic [DATA_W-1:0] dataQ,
  output logic              rxc,
  output logic              fe,
  output logic              ovr,
  output logic              rxb9,
  output logic              irq
);
  logic [DATA_W:0] shiftQ;
  logic            ovrPend;
  logic            addrBit, dropFrame, loadFrame;

  assign addrBit   = nineBit ? shiftQ[DATA_W] : strobe.bitVal;
  assign dropFrame = mpMode && !addrBit;
  assign loadFrame = strobe.frameDone && !dropFrame;
  assign irq       = rxcIe & rxc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {rxcIe, mpMode, dblSpeed, nineBit, rxEn} <= '0;
    else if (ctrlWr) {rxcIe, mpMode, dblSpeed, nineBit, rxEn} <= ctrlWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else if (strobe.sampleBit) shiftQ[strobe.bitIdx] <= strobe.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      rxc     <= 1'b0;
      fe      <= 1'b0;
      ovr     <= 1'b0;
      ovrPend <= 1'b0;
      rxb9    <= 1'b1;
    end else if (loadFrame) begin
      if (rxc && !dataRd) begin
        ovrPend <= 1'b1;
      end else begin
        dataQ   <= shiftQ[DATA_W-1:0];
        if (nineBit) rxb9 <= shiftQ[DATA_W];
        fe      <= ~strobe.bitVal;
        rxc     <= 1'b1;
        ovr     <= dataRd & ovrPend;
        ovrPend <= 1'b0;
      end
    end else if (dataRd) begin
      rxc <= 1'b0;
      if (ovrPend) begin
        ovr     <= 1'b1;
        ovrPend <= 1'b0;
      end
    end
  end

  // R4: overrun only becomes visible through a data read
  p_ovr_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovr) |-> $past(dataRd));
  // R5: a read with no arriving frame leaves receive-complete clear
  p_rxc_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strobe.frameDone) |=> !rxc);
  // R6: a filtered data frame leaves data and flags untouched
  p_mp_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && mpMode && !addrBit && !dataRd) |=> ($stable(dataQ) && $stable({rxc, fe, ovr})));
  // R7: while disabled, only a read may change the flags
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !dataRd) |=> $stable({rxc, fe, ovr}));
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int OVS_SLOW = 16,
  parameter int OVS_FAST = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              rxd,
  input  logic              ctrlWr,
  input  logic [4:0]        ctrlWdata,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rdData,
  output logic [4:0]        ctrlRdata,
  output logic [3:0]        statusOut,
  output logic              irq
);
  rxStrobe_t strobe;
  logic rxEn, nineBit, dblSpeed, mpMode, rxcIe;
  logic rxc, fe, ovr, rxb9;

  uart_mp_rx_ctrl #(.OVS_SLOW(OVS_SLOW), .OVS_FAST(OVS_FAST), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxd(rxd),
    .rxEn(rxEn), .nineBit(nineBit), .dblSpeed(dblSpeed), .strobe(strobe)
  );

  uart_mp_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .dataRd(dataRd), .rxEn(rxEn), .nineBit(nineBit), .dblSpeed(dblSpeed),
    .mpMode(mpMode), .rxcIe(rxcIe), .dataQ(rdData), .rxc(rxc), .fe(fe),
    .ovr(ovr), .rxb9(rxb9), .irq(irq)
  );

  assign ctrlRdata = {rxcIe, mpMode, dblSpeed, nineBit, rxEn};
  assign statusOut = {rxc, fe, ovr, rxb9};

  // R9: interrupt tracks receive-complete under its enable
  p_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusOut[3] && ctrlRdata[4]));
endmodule

// File: tb/uart_mp_rx_test.sv
module uart_mp_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b1;
  logic       rxd = 1'b1;
  logic       ctrlWr = 1'b0;
  logic [4:0] ctrlWdata = '0;
  logic       dataRd = 1'b0;
  logic [7:0] rdData;
  logic [4:0] ctrlRdata;
  logic [3:0] statusOut;
  logic       irq;

  int testsRun = 0;
  int testsFailed = 0;
  int curOvs = 16;
  bit doneFlag = 0;

  uart_mp_rx uut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxd(rxd), .ctrlWr(ctrlWr),
    .ctrlWdata(ctrlWdata), .dataRd(dataRd), .rdData(rdData), .ctrlRdata(ctrlRdata),
    .statusOut(statusOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [4:0] v);
    @(negedge clk); ctrlWr = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWr = 1'b0;
    curOvs = v[2] ? 8 : 16;
  endtask

  task automatic readData();
    @(negedge clk); dataRd = 1'b1;
    @(negedge clk); dataRd = 1'b0;
    @(negedge clk);
  endtask

  // drive one frame; glitchBit >= 0 inverts one cycle at mid-bit of that data bit
  task automatic sendFrame(input logic [8:0] d, input int nb, input logic stopB, input int glitchBit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (curOvs) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      for (int c = 0; c < curOvs; c++) begin
        rxd = (i == glitchBit && c == curOvs/2) ? ~d[i] : d[i];
        @(negedge clk);
      end
    end
    rxd = stopB;
    repeat (curOvs) @(negedge clk);
    rxd = 1'b1;
    repeat (curOvs + 6) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!doneFlag) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(statusOut == 4'b0001, "R1 status", statusOut, 4'b0001);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(ctrlRdata == 5'b0, "R1 ctrl", ctrlRdata, 0);

    for (int sp = 0; sp < 2; sp++) begin
      writeCtrl(sp ? 5'b00101 : 5'b00001);
      check(ctrlRdata == (sp ? 5'b00101 : 5'b00001), "R2 ctrl readback", ctrlRdata, sp ? 5 : 1);
      // R2 sweep of character values
      for (int d = 0; d < 256; d += 3) begin
        sendFrame(9'(d), 8, 1'b1, -1);
        check(rdData == 8'(d), "R2 data", rdData, d);
        check(statusOut[3:2] == 2'b10, "R2 rxc/fe", statusOut[3:2], 2);
        readData();
        check(statusOut[3] == 1'b0, "R5 rxc cleared by read", statusOut[3], 0);
      end
      // R4 buffered overrun
      sendFrame(9'h3C, 8, 1'b1, -1);
      sendFrame(9'hC3, 8, 1'b1, -1);
      check(statusOut[1] == 1'b0, "R4 ovr hidden before read", statusOut[1], 0);
      check(rdData == 8'h3C, "R4 old data kept", rdData, 8'h3C);
      readData();
      check(statusOut[1] == 1'b1, "R4 ovr after read", statusOut[1], 1);
      check(statusOut[3] == 1'b0, "R4 rxc after read", statusOut[3], 0);
      sendFrame(9'h5A, 8, 1'b1, -1);
      check(statusOut[1] == 1'b0, "R5 ovr cleared by clean load", statusOut[1], 0);
      check(rdData == 8'h5A, "R5 new data", rdData, 8'h5A);
      readData();
      // R11 majority vote
      sendFrame(9'hA5, 8, 1'b1, 3);
      check(rdData == 8'hA5, "R11 glitch rejected", rdData, 8'hA5);
      readData();
      // R10 false start
      @(negedge clk); rxd = 1'b0;
      repeat (curOvs/4) @(negedge clk);
      rxd = 1'b1;
      repeat (curOvs * 12) @(negedge clk);
      check(statusOut[3] == 1'b0, "R10 false start", statusOut[3], 0);
    end

    // R9 interrupt
    writeCtrl(5'b10001);
    check(irq == 1'b0, "R9 irq idle", irq, 0);
    sendFrame(9'h11, 8, 1'b1, -1);
    check(irq == 1'b1, "R9 irq set", irq, 1);
    readData();
    check(irq == 1'b0, "R9 irq cleared", irq, 0);

    // R3 nine-bit mode
    writeCtrl(5'b00011);
    sendFrame(9'h1A5, 9, 1'b1, -1);
    check(rdData == 8'hA5, "R3 low bits", rdData, 8'hA5);
    check(statusOut[0] == 1'b1, "R3 ninth bit one", statusOut[0], 1);
    readData();
    sendFrame(9'h05A, 9, 1'b1, -1);
    check(statusOut[0] == 1'b0, "R3 ninth bit zero", statusOut[0], 0);
    readData();

    // R8 framing error
    writeCtrl(5'b00001);
    sendFrame(9'h77, 8, 1'b0, -1);
    check(statusOut[2] == 1'b1, "R8 fe set", statusOut[2], 1);
    readData();
    sendFrame(9'h78, 8, 1'b1, -1);
    check(statusOut[2] == 1'b0, "R8 fe clear", statusOut[2], 0);
    readData();

    // R6 address filter, nine-bit
    writeCtrl(5'b01011);
    sendFrame(9'h042, 9, 1'b1, -1);
    check(statusOut[3] == 1'b0, "R6 data frame dropped", statusOut[3], 0);
    check(rdData == 8'h78, "R6 data kept", rdData, 8'h78);
    sendFrame(9'h133, 9, 1'b1, -1);
    check(statusOut[3] == 1'b1, "R6 address loaded", statusOut[3], 1);
    check(rdData == 8'h33, "R6 address value", rdData, 8'h33);
    readData();
    // R6 address filter, 8-bit: stop bit zero marks data
    writeCtrl(5'b01001);
    sendFrame(9'h99, 8, 1'b0, -1);
    check(statusOut[3:2] == 2'b00, "R6 8-bit data dropped", statusOut[3:2], 0);

    // R7 disabled receiver
    writeCtrl(5'b00001);
    sendFrame(9'h66, 8, 1'b0, -1);
    writeCtrl(5'b00000);
    sendFrame(9'h12, 8, 1'b1, -1);
    check(statusOut[3:1] == 3'b110, "R7 flags held", statusOut[3:1], 3'b110);
    check(rdData == 8'h66, "R7 data held", rdData, 8'h66);
    readData();
    sendFrame(9'h13, 8, 1'b1, -1);
    check(statusOut[3] == 1'b0, "R7 no flag while off", statusOut[3], 0);

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule